// File: doc/BRIEF.md
# Multi-Lane Serial Shift Engine

This block serialises parallel words onto one, two or four output lanes and rebuilds parallel words from the matching input lanes. A single 32-bit control word sets its behaviour at run time. The control word chooses the bit order, the idle line level and the output polarity. It also gives the lane width, the word length (1 to 16 bits) and the frame length (1 to 64 bits). A frame is carried as consecutive words, and the last word is cut short to the bits left in the frame.

Shifting advances only on cycles where the external `tick_i` is high. The baud source sits outside this block. A frame may start only when the start qualifier allows it. The qualifier can block every start, follow the level of `shift_ctl_i` in either polarity, or allow one frame per edge of `shift_ctl_i`. Transmit words are taken through a valid/ready handshake. Each completed receive word is presented with a one-cycle valid strobe.

The control word must be changed only while no frame is in progress.

Top module: `lane_shift_engine`

## Requirements
- R1: After reset the engine is idle. In that state `lane_o` is all zero with the control word at zero, `rx_valid_o` is 0, and `tx_ready_o` is 0 while `tick_i` is 0.
- R2: Bits 9:8 form the start qualifier. Value 0 blocks every frame start. Value 1 allows a start only while `shift_ctl_i` is 1, and value 2 only while it is 0. When a start is blocked, `tx_ready_o` stays 0 and the lanes stay passive.
- R3: Start qualifier value 3 allows exactly one frame start after each edge of `shift_ctl_i`, whatever its level. Without a new edge, no further frame starts.
- R4: Bits 27:24 hold the word length minus one. With bit 0 at 0, word bits go out least significant first, starting from bit 0. A word of n bits takes ceil(n / lanes) steps, and one step is taken per tick.
- R5: With bit 0 at 1, a word of n bits goes out most significant first, starting from bit n-1.
- R6: Bits 3:2 set the lane width: 2 selects two lanes, 3 selects four lanes, and 0 or 1 select a single lane (lane 0). Within a step, a lower lane index carries an earlier bit of the shift order. Lanes outside the width, and sequence positions past the word end, carry the passive level.
- R7: Bit 1 is the passive level. It is driven on every lane whenever no word is being shifted: when idle, between frames, and while waiting for a late word.
- R8: A value of 1 in bits 7:6 inverts the data bits on the lanes. Values 0, 2 and 3 leave them unchanged. Passive-level bits are never inverted.
- R9: Bits 21:16 hold the frame length minus one. Each word gets min(word length, bits left) bits. At the tick that ends a word with bits still left, `tx_ready_o` is 1. If no word is offered there, the engine waits until one is offered on a later tick.
- R10: Each input lane is sampled on the tick that ends its step, and bits are placed into the word positions they stand for in the shift order. One cycle after the tick that ends a word, `rx_valid_o` is 1 for one cycle with that word on `rx_data_o`. Positions above the word length read 0.
- R11: `lane_oe_o` follows control bit 4 (1 = lanes drive, 0 = lanes are inputs).
- R12: `tx_ready_o` is 1 only in a tick cycle where the engine needs a word. A word offered in any other cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 32 | Control word |
| tick_i | input | 1 | Shift step enable |
| shift_ctl_i | input | 1 | Start qualifier input |
| tx_data_i | input | 16 | Transmit word |
| tx_valid_i | input | 1 | Transmit word offered |
| tx_ready_o | output | 1 | Transmit word taken this cycle when valid |
| rx_data_o | output | 16 | Received word |
| rx_valid_o | output | 1 | Received word strobe |
| lane_o | output | 4 | Output data lanes |
| lane_oe_o | output | 1 | Lane drive enable |
| lane_i | input | 4 | Input data lanes |

## Verification
`tx_ready_o` is combinational and is read in the tick cycle itself, 1 ns after the inputs are driven. A word accepted at a tick rising edge appears on `lane_o` right after that edge, and each later step appears after the tick that advances it. The bench therefore reads the lanes at the falling edge that follows each tick, and drives the input lanes for that step at the same moment. `rx_valid_o` and `rx_data_o` are registered on the tick that ends a word, so they are read at that same falling edge and are gone one cycle later. An edge on `shift_ctl_i` arms the edge qualifier one clock later, so the bench lets two clocks pass after each edge before it issues a start tick.

// File: rtl/lane_shift_pkg.sv
`timescale 1ns/1ps
package lane_shift_pkg;
  localparam int CTL_DIR     = 0;
  localparam int CTL_PDL     = 1;
  localparam int CTL_LANE_LO = 2;
  localparam int CTL_OE      = 4;
  localparam int CTL_INV_LO  = 6;
  localparam int CTL_GATE_LO = 8;
  localparam int CTL_FLEN_LO = 16;
  localparam int CTL_WLEN_LO = 24;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WAIT} eng_state_e;
  typedef enum logic [1:0] {GATE_OFF, GATE_HIGH, GATE_LOW, GATE_EDGE} gate_mode_e;

  // log2 of active lane count; reserved code falls back to one lane
  function automatic logic [1:0] lane_shift_of(input logic [1:0] mode);
    case (mode)
      2'd2:    return 2'd1;
      2'd3:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/lane_shift_gate.sv
`timescale 1ns/1ps
module lane_shift_gate
  import lane_shift_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       ctl_i,
  input  logic       take_i,
  output logic       ok_o
);
  logic ctl_q, armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      ctl_q   <= ctl_i;
      // a fresh edge wins over a start consumed in the same cycle
      armed_q <= (ctl_i != ctl_q) | (armed_q & ~take_i);
    end
  end

  always_comb begin
    case (gate_mode_e'(mode_i))
      GATE_HIGH: ok_o = ctl_i;
      GATE_LOW:  ok_o = ~ctl_i;
      GATE_EDGE: ok_o = armed_q;
      default:   ok_o = 1'b0;
    endcase
  end

  AST_EDGE_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i != ctl_q) |=> armed_q); // R3
endmodule

// File: rtl/lane_shift_map.sv
`timescale 1ns/1ps
module lane_shift_map #(
  parameter int WORD_W = 16,
  parameter int LANES  = 4,
  parameter int POS_W  = 4,
  parameter int NB_W   = 5,
  parameter int CNT_W  = 7
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [NB_W-1:0]   nbits_i,
  input  logic [POS_W-1:0]  step_i,
  input  logic [1:0]        lsh_i,
  input  logic              dir_i,
  input  logic              pdl_i,
  input  logic              inv_i,
  input  logic [LANES-1:0]  lane_i,
  input  logic [WORD_W-1:0] acc_i,
  output logic [LANES-1:0]  lane_o,
  output logic [WORD_W-1:0] acc_o
);
  logic [LANES-1:0] live;
  logic [POS_W-1:0] pos [LANES];
  logic [CNT_W-1:0] width;

  assign width = CNT_W'(1) << lsh_i;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [CNT_W-1:0] seq;
    logic [CNT_W-1:0] rpos;
    assign seq       = (CNT_W'(step_i) << lsh_i) + CNT_W'(j);
    assign live[j]   = (CNT_W'(j) < width) && (seq < CNT_W'(nbits_i));
    assign rpos      = dir_i ? (CNT_W'(nbits_i) - CNT_W'(1) - seq) : seq;
    assign pos[j]    = POS_W'(rpos);
    assign lane_o[j] = live[j] ? (word_i[pos[j]] ^ inv_i) : pdl_i;
  end

  always_comb begin
    acc_o = acc_i;
    for (int j = 0; j < LANES; j++)
      if (live[j]) acc_o[pos[j]] = lane_i[j];
  end
endmodule

// File: rtl/lane_shift_engine.sv
`timescale 1ns/1ps
module lane_shift_engine
  import lane_shift_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int LANES  = 4,
  parameter int FLEN_W = 6,
  parameter int WLEN_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       ctrl_i,
  input  logic              tick_i,
  input  logic              shift_ctl_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic [LANES-1:0]  lane_o,
  output logic              lane_oe_o,
  input  logic [LANES-1:0]  lane_i
);
  localparam int POS_W = $clog2(WORD_W);
  localparam int NB_W  = POS_W + 1;
  localparam int REM_W = FLEN_W + 1;
  localparam int CNT_W = POS_W + 3;

  eng_state_e        st_q;
  logic [WORD_W-1:0] word_q, acc_q, acc_nxt;
  logic [NB_W-1:0]   n_q, wlen, n_load;
  logic [POS_W-1:0]  k_q;
  logic [REM_W-1:0]  rem_q, flen, rem_src;
  logic [1:0]        lsh;
  logic              dir, pdl, inv, gate_ok, last_step, load, start;
  logic [LANES-1:0]  map_lanes;
  logic              unused_ctrl;

  assign dir       = ctrl_i[CTL_DIR];
  assign pdl       = ctrl_i[CTL_PDL];
  assign lsh       = lane_shift_of(ctrl_i[CTL_LANE_LO +: 2]);
  assign inv       = (ctrl_i[CTL_INV_LO +: 2] == 2'd1);
  assign lane_oe_o = ctrl_i[CTL_OE];
  assign wlen      = NB_W'(ctrl_i[CTL_WLEN_LO +: WLEN_W]) + NB_W'(1);
  assign flen      = REM_W'(ctrl_i[CTL_FLEN_LO +: FLEN_W]) + REM_W'(1);
  assign unused_ctrl = ^{ctrl_i[31:28], ctrl_i[23:22], ctrl_i[15:10], ctrl_i[5]};

  assign rem_src   = (st_q == ST_IDLE) ? flen : rem_q;
  assign n_load    = (rem_src < REM_W'(wlen)) ? NB_W'(rem_src) : wlen;
  assign last_step = ((CNT_W'(k_q) + CNT_W'(1)) << lsh) >= CNT_W'(n_q);

  assign tx_ready_o = tick_i & (((st_q == ST_IDLE) & gate_ok)
                              | ((st_q == ST_RUN) & last_step & (rem_q != '0))
                              |  (st_q == ST_WAIT));
  assign load  = tx_ready_o & tx_valid_i;
  assign start = load & (st_q == ST_IDLE);

  lane_shift_gate u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (ctrl_i[CTL_GATE_LO +: 2]),
    .ctl_i  (shift_ctl_i),
    .take_i (start),
    .ok_o   (gate_ok)
  );

  lane_shift_map #(
    .WORD_W (WORD_W), .LANES (LANES), .POS_W (POS_W), .NB_W (NB_W), .CNT_W (CNT_W)
  ) u_map (
    .word_i  (word_q),
    .nbits_i (n_q),
    .step_i  (k_q),
    .lsh_i   (lsh),
    .dir_i   (dir),
    .pdl_i   (pdl),
    .inv_i   (inv),
    .lane_i  (lane_i),
    .acc_i   (acc_q),
    .lane_o  (map_lanes),
    .acc_o   (acc_nxt)
  );

  assign lane_o = (st_q == ST_RUN) ? map_lanes : {LANES{pdl}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
      acc_q      <= '0;
    end else begin
      rx_valid_o <= 1'b0;
      case (st_q)
        ST_IDLE, ST_WAIT: if (load) st_q <= ST_RUN;
        ST_RUN: if (tick_i) begin
          if (!last_step) acc_q <= acc_nxt;
          else begin
            rx_data_o  <= acc_nxt;
            rx_valid_o <= 1'b1;
            acc_q      <= '0;
            if (rem_q == '0) st_q <= ST_IDLE;
            else if (!load)  st_q <= ST_WAIT;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      n_q    <= '0;
      k_q    <= '0;
      rem_q  <= '0;
    end else if (load) begin
      word_q <= tx_data_i;
      n_q    <= n_load;
      k_q    <= '0;
      rem_q  <= rem_src - REM_W'(n_load);
    end else if (st_q == ST_RUN && tick_i && !last_step) begin
      k_q    <= k_q + POS_W'(1);
    end
  end

  AST_GATE_OFF_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && ctrl_i[CTL_GATE_LO +: 2] == 2'd0) |=> (st_q == ST_IDLE)); // R2
  AST_STEP_IN_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN) |-> ((CNT_W'(k_q) << lsh) < CNT_W'(n_q))); // R4
  AST_RX_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(tick_i)); // R10
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && !tick_i) |=> (st_q == ST_RUN && $stable(k_q))); // R12
  AST_IDLE_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !tick_i) |=> (st_q == ST_IDLE)); // R12
endmodule

// File: tb/lane_shift_engine_tb.sv
`timescale 1ns/1ps
module lane_shift_engine_tb;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [31:0] ctrl_i = '0;
  logic        tick_i = 1'b0, shift_ctl_i = 1'b0, tx_valid_i = 1'b0;
  logic [15:0] tx_data_i = '0;
  logic        tx_ready_o, rx_valid_o, lane_oe_o;
  logic [15:0] rx_data_o;
  logic [3:0]  lane_o, lane_i = '0;
  int          checks = 0, errs = 0;
  logic [15:0] txw [64];
  logic [15:0] rxw [64];

  always #4 clk = ~clk;

  lane_shift_engine u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ctrl_i(ctrl_i), .tick_i(tick_i),
    .shift_ctl_i(shift_ctl_i), .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i),
    .tx_ready_o(tx_ready_o), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
    .lane_o(lane_o), .lane_oe_o(lane_oe_o), .lane_i(lane_i)
  );

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(input bit dir, input bit pdl, input logic [1:0] dsm,
      input bit oe, input logic [1:0] ocfg, input logic [1:0] trm, input int fl, input int wl);
    return {4'b0, 4'(wl), 2'b0, 6'(fl), 6'b0, trm, ocfg, 1'b0, oe, dsm, pdl, dir};
  endfunction

  function automatic int lanes_of(input logic [1:0] dsm);
    return (dsm == 2'd2) ? 2 : (dsm == 2'd3) ? 4 : 1;
  endfunction

  function automatic logic [15:0] msk(input int n);
    return (n >= 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
  endfunction

  function automatic logic [3:0] exp_lanes(input logic [15:0] w, input int n, input int k,
      input int nl, input bit dir, input bit pdl, input bit inv);
    logic [3:0] r;
    for (int j = 0; j < 4; j++) begin
      int s = k * nl + j;
      if (j < nl && s < n) r[j] = (dir ? w[n-1-s] : w[s]) ^ inv;
      else r[j] = pdl;
    end
    return r;
  endfunction

  task automatic step_tick(input bit valid, input logic [15:0] data, output bit rdy);
    tick_i = 1'b1; tx_valid_i = valid; tx_data_i = data;
    #1 rdy = tx_ready_o;
    @(posedge clk);
    @(negedge clk);
    tick_i = 1'b0; tx_valid_i = 1'b0;
  endtask

  task automatic run_frame(input logic [31:0] c, input bit stall_en);
    int nl, wl, fl, rem, n, steps, wi;
    bit dir, pdl, inv, stall, rdy;
    logic [3:0] drv;
    string tag;
    ctrl_i = c;
    @(negedge clk); @(negedge clk);
    nl = lanes_of(c[3:2]); dir = c[0]; pdl = c[1]; inv = (c[7:6] == 2'd1);
    wl = int'(c[27:24]) + 1; fl = int'(c[21:16]) + 1;
    tag = inv ? "R8" : (nl > 1) ? "R6" : dir ? "R5" : "R4";
    chk("R11", {31'b0, lane_oe_o}, {31'b0, c[4]});
    for (int w = 0; w < 64; w++) begin txw[w] = 16'($urandom); rxw[w] = 16'($urandom); end
    rem = fl; wi = 0; stall = 0;
    step_tick(1'b1, txw[0], rdy);
    chk("R12", {31'b0, rdy}, 32'd1);
    forever begin
      n = (rem < wl) ? rem : wl;
      rem -= n;
      steps = (n + nl - 1) / nl;
      for (int k = 0; k < steps; k++) begin
        chk(tag, {28'b0, lane_o}, {28'b0, exp_lanes(txw[wi], n, k, nl, dir, pdl, inv)});
        for (int j = 0; j < 4; j++) begin
          int s = k * nl + j;
          if (j < nl && s < n) drv[j] = rxw[wi][dir ? n-1-s : s];
          else drv[j] = 1'($urandom);
        end
        lane_i = drv;
        if (k < steps - 1) begin
          step_tick(1'b1, 16'($urandom), rdy);
          chk("R12", {31'b0, rdy}, 32'd0);
          chk("R10", {31'b0, rx_valid_o}, 32'd0);
        end else begin
          stall = stall_en && rem > 0 && ($urandom % 3 == 0);
          if (rem > 0 && !stall) step_tick(1'b1, txw[wi+1], rdy);
          else step_tick(1'b0, 16'h0, rdy);
          chk("R9", {31'b0, rdy}, (rem > 0) ? 32'd1 : 32'd0);
          chk("R10", {31'b0, rx_valid_o}, 32'd1);
          chk("R10", {16'b0, rx_data_o}, {16'b0, rxw[wi] & msk(n)});
        end
        repeat ($urandom % 2) @(negedge clk);
      end
      if (rem == 0) break;
      wi++;
      if (stall) begin
        chk("R7", {28'b0, lane_o}, {28'b0, {4{pdl}}});
        repeat (2) @(negedge clk);
        step_tick(1'b1, txw[wi], rdy);
        chk("R9", {31'b0, rdy}, 32'd1);
      end
    end
    chk("R7", {28'b0, lane_o}, {28'b0, {4{pdl}}});
  endtask

  task automatic blocked_try(input string req, input bit pdl);
    bit rdy;
    step_tick(1'b1, 16'hA5A5, rdy);
    chk(req, {31'b0, rdy}, 32'd0);
    chk(req, {28'b0, lane_o}, {28'b0, {4{pdl}}});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: run did not complete");
    finish_sim();
  end

  initial begin
    void'($urandom(32'd7177));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", {28'b0, lane_o}, 32'd0);
    chk("R1", {31'b0, rx_valid_o}, 32'd0);
    chk("R1", {31'b0, tx_ready_o}, 32'd0);
    chk("R11", {31'b0, lane_oe_o}, 32'd0);

    // R2 gating by level and the blocking mode
    ctrl_i = mk_ctrl(0, 1, 2'd0, 1, 2'd0, 2'd0, 7, 7);
    @(negedge clk);
    blocked_try("R2", 1'b1);
    ctrl_i = mk_ctrl(0, 0, 2'd0, 0, 2'd0, 2'd1, 7, 7);
    shift_ctl_i = 1'b0;
    @(negedge clk);
    blocked_try("R2", 1'b0);
    shift_ctl_i = 1'b1;
    run_frame(mk_ctrl(0, 0, 2'd0, 0, 2'd0, 2'd1, 7, 7), 0);
    ctrl_i = mk_ctrl(0, 1, 2'd0, 0, 2'd0, 2'd2, 7, 7);
    @(negedge clk);
    blocked_try("R2", 1'b1);
    shift_ctl_i = 1'b0;
    run_frame(mk_ctrl(1, 1, 2'd0, 1, 2'd0, 2'd2, 11, 7), 0);

    // R3 one frame per edge
    shift_ctl_i = 1'b1;
    run_frame(mk_ctrl(0, 0, 2'd2, 1, 2'd0, 2'd3, 15, 15), 0);
    blocked_try("R3", 1'b0);
    shift_ctl_i = 1'b0;
    run_frame(mk_ctrl(1, 1, 2'd3, 1, 2'd0, 2'd3, 7, 7), 0);
    blocked_try("R3", 1'b1);

    // directed corners, level gate high
    shift_ctl_i = 1'b1;
    run_frame(mk_ctrl(0, 0, 2'd0, 1, 2'd0, 2'd1, 15, 15), 0);  // R4 16-bit word
    run_frame(mk_ctrl(1, 0, 2'd0, 1, 2'd0, 2'd1, 0, 0), 0);    // R5 1-bit frame
    run_frame(mk_ctrl(0, 1, 2'd3, 1, 2'd0, 2'd1, 63, 0), 0);   // R6 64 one-bit words
    run_frame(mk_ctrl(1, 0, 2'd3, 1, 2'd0, 2'd1, 39, 15), 1);  // R9 truncated last word
    run_frame(mk_ctrl(0, 1, 2'd2, 0, 2'd0, 2'd1, 8, 2), 1);    // R6 dual, padded step
    run_frame(mk_ctrl(1, 1, 2'd1, 1, 2'd0, 2'd1, 9, 4), 0);    // R6 reserved -> single
    run_frame(mk_ctrl(0, 0, 2'd2, 1, 2'd1, 2'd1, 13, 6), 0);   // R8 inverted
    run_frame(mk_ctrl(0, 1, 2'd0, 1, 2'd2, 2'd1, 5, 5), 0);    // R8 reserved -> plain
    run_frame(mk_ctrl(1, 0, 2'd3, 1, 2'd3, 2'd1, 5, 5), 0);    // R8 reserved -> plain

    // random mix
    for (int f = 0; f < 40; f++) begin
      logic [1:0] trm;
      trm = ($urandom % 2 == 0) ? 2'd1 : 2'd2;
      shift_ctl_i = (trm == 2'd1);
      @(negedge clk);
      run_frame(mk_ctrl(1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
                        2'($urandom), trm, int'($urandom % 64), int'($urandom % 16)), 1);
    end
    finish_sim();
  end
endmodule